// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small 8-bit processor core. It takes an operation code, the accumulator, one 8-bit operand and the current four condition flags. In the same cycle it produces an 8-bit result, the next value of the flags, and an enable that tells the core whether the result goes back into the destination register. The datapath is purely combinational. A four-bit flag register inside the block captures the new flags on every cycle in which the core marks the operation valid.

The flag nibble is laid out as zero (bit 3), subtract (bit 2), half-carry (bit 1) and carry (bit 0). Each operation applies its own rule to each flag: it computes the flag, forces it high, forces it low, or passes it through from the incoming nibble. Half-carry is the carry out of bit 3 on additions and the borrow into bit 4 on subtractions. The decimal-adjust operation uses the incoming subtract, half-carry and carry flags to correct a packed-BCD sum or difference.

Top module: `acc_alu`

## Requirements
- R1: Op 0 (add) produces acc+opnd and op 1 (add with carry) produces acc+opnd+C. Both set Z when the 8-bit result is zero, set H on a carry out of bit 3, set C on a carry out of bit 7, clear N, and assert write-back.
- R2: Op 2 (subtract) produces acc-opnd and op 3 (subtract with carry) produces acc-opnd-C. Both set N, set Z on a zero result, set H on a borrow into bit 4 (the incoming carry included for op 3), set C on a borrow out of bit 7, and assert write-back.
- R3: Op 7 (compare) gives the same flags as op 2 and leaves write-back low. The result output then equals the accumulator.
- R4: Op 4 (AND) produces acc&opnd, sets Z from the result, clears N and C, forces H to 1, and asserts write-back.
- R5: Op 5 (OR) and op 6 (XOR) produce acc|opnd and acc^opnd. Both set Z from the result, clear N, H and C, and assert write-back.
- R6: Op 8 (increment) produces opnd+1 and op 9 (decrement) produces opnd-1. Both set Z from the result and pass C through unchanged. Increment clears N and sets H when the low nibble of the operand is 0xF. Decrement sets N and sets H when the low nibble of the operand is 0x0. Write-back is asserted.
- R7: Op 11 (complement) produces ~acc, sets N and H, passes Z and C through, and asserts write-back.
- R8: Op 12 inverts C and op 13 forces C to 1. Both clear N and H, pass Z through, leave write-back low, and output the accumulator.
- R9: Op 10 (decimal adjust) with N=0 adds 0x06 if H=1 or the low nibble of acc exceeds 9. It adds 0x60 and sets C if C=1 or acc exceeds 0x99, and otherwise leaves C at 0. It sets Z from the result, clears H, keeps N, and asserts write-back.
- R10: Op 10 with N=1 subtracts 0x06 if H=1 and subtracts 0x60 if C=1. C is kept, H is cleared, N is kept, Z is set from the result, and write-back is asserted.
- R11: Op codes 14 and 15 are no-ops. The output flags equal the incoming flags, the result equals the accumulator, and write-back is low.
- R12: Synchronous reset clears the flag register. On a clock edge with the valid input high, the register loads the flags computed that cycle. With the valid input low, it holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | Operation is issued this cycle; the flag register captures flg_o |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand; source for increment and decrement |
| flg_i | input | 4 | Incoming flags {Z,N,H,C} |
| res_o | output | 8 | Result |
| flg_o | output | 4 | Next flags {Z,N,H,C}, combinational |
| wr_o | output | 1 | Result write-back enable |
| flg_q_o | output | 4 | Registered flags |

## Verification
The combinational assertions assume that op_i, acc_i, opnd_i and flg_i are settled and known at every rising edge after reset. The bench meets this by driving the inputs in steps of one nanosecond, so they are stable across each edge. The register assertions assume that op_valid_i is known from reset onward; the bench holds it low except during the registered-flag tests, where it is driven at falling edges. The sweep applies every accumulator/operand pair with both carry values for the two-operand operations. For the single-operand operations it applies all sixteen flag nibbles with every accumulator value, which covers each branch of the decimal adjust.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int FLAG_W = 4;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_CMP  = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_DADJ = 4'd10,
        OP_CPL  = 4'd11,
        OP_CCF  = 4'd12,
        OP_SCF  = 4'd13,
        OP_NOP0 = 4'd14,
        OP_NOP1 = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    function automatic logic is_zero(input logic [DATA_W-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    input  logic              cin,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              hout
);
    logic [NIB_W:0]  lo;
    logic [DATA_W:0] full;

    always_comb begin
        if (sub) begin
            lo   = {1'b0, x[NIB_W-1:0]} - {1'b0, y[NIB_W-1:0]} - {{NIB_W{1'b0}}, cin};
            full = {1'b0, x} - {1'b0, y} - {{DATA_W{1'b0}}, cin};
        end else begin
            lo   = {1'b0, x[NIB_W-1:0]} + {1'b0, y[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
            full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
        end
        sum  = full[DATA_W-1:0];
        cout = full[DATA_W];
        hout = lo[NIB_W];
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
(
    input  logic_op_e         sel,
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic [DATA_W-1:0] res
);
    always_comb begin
        unique case (sel)
            LG_AND:  res = x & y;
            LG_OR:   res = x | y;
            default: res = x ^ y;
        endcase
    end
endmodule

// File: rtl/alu_daa.sv
module alu_daa
    import alu_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  flags_t            fin,
    output logic [DATA_W-1:0] res,
    output logic              cout
);
    localparam logic [DATA_W-1:0] LO_FIX = 8'h06;
    localparam logic [DATA_W-1:0] HI_FIX = 8'h60;
    localparam logic [DATA_W-1:0] BCD_MAX = 8'h99;
    localparam logic [NIB_W-1:0]  DIG_MAX = 4'd9;

    logic [DATA_W-1:0] corr;

    always_comb begin
        corr = '0;
        cout = fin.c;
        if (!fin.n) begin
            if (fin.h || (a[NIB_W-1:0] > DIG_MAX)) corr = corr | LO_FIX;
            if (fin.c || (a > BCD_MAX)) begin
                corr = corr | HI_FIX;
                cout = 1'b1;
            end
            res = a + corr;
        end else begin
            if (fin.h) corr = corr | LO_FIX;
            if (fin.c) corr = corr | HI_FIX;
            res = a - corr;
        end
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [FLAG_W-1:0] flg_i,
    output logic [DATA_W-1:0] res_o,
    output logic [FLAG_W-1:0] flg_o,
    output logic              wr_o,
    output logic [FLAG_W-1:0] flg_q_o
);
    alu_op_e op;
    flags_t  fin;
    flags_t  fout;
    flags_t  flg_q;

    assign op  = alu_op_e'(op_i);
    assign fin = flags_t'(flg_i);

    // adder operand steering
    logic [DATA_W-1:0] as_x, as_y, as_sum;
    logic              as_cin, as_sub, as_c, as_h;

    always_comb begin
        as_x   = acc_i;
        as_y   = opnd_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        unique case (op)
            OP_ADC: as_cin = fin.c;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBC: begin
                as_sub = 1'b1;
                as_cin = fin.c;
            end
            OP_INC, OP_DEC: begin
                as_x   = opnd_i;
                as_y   = {{(DATA_W-1){1'b0}}, 1'b1};
                as_sub = (op == OP_DEC);
            end
            default: ;
        endcase
    end

    alu_addsub u_addsub (
        .x    (as_x),
        .y    (as_y),
        .cin  (as_cin),
        .sub  (as_sub),
        .sum  (as_sum),
        .cout (as_c),
        .hout (as_h)
    );

    logic_op_e         lg_sel;
    logic [DATA_W-1:0] lg_res;

    always_comb begin
        unique case (op)
            OP_AND:  lg_sel = LG_AND;
            OP_OR:   lg_sel = LG_OR;
            default: lg_sel = LG_XOR;
        endcase
    end

    alu_logic u_logic (
        .sel (lg_sel),
        .x   (acc_i),
        .y   (opnd_i),
        .res (lg_res)
    );

    logic [DATA_W-1:0] da_res;
    logic              da_c;

    alu_daa u_daa (
        .a    (acc_i),
        .fin  (fin),
        .res  (da_res),
        .cout (da_c)
    );

    // result, flag and write-back selection
    always_comb begin
        res_o = acc_i;
        fout  = fin;
        wr_o  = 1'b0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                res_o = as_sum;
                fout  = '{z: is_zero(as_sum), n: 1'b0, h: as_h, c: as_c};
                wr_o  = 1'b1;
            end
            OP_SUB, OP_SBC: begin
                res_o = as_sum;
                fout  = '{z: is_zero(as_sum), n: 1'b1, h: as_h, c: as_c};
                wr_o  = 1'b1;
            end
            OP_CMP: begin
                fout  = '{z: is_zero(as_sum), n: 1'b1, h: as_h, c: as_c};
            end
            OP_AND: begin
                res_o = lg_res;
                fout  = '{z: is_zero(lg_res), n: 1'b0, h: 1'b1, c: 1'b0};
                wr_o  = 1'b1;
            end
            OP_OR, OP_XOR: begin
                res_o = lg_res;
                fout  = '{z: is_zero(lg_res), n: 1'b0, h: 1'b0, c: 1'b0};
                wr_o  = 1'b1;
            end
            OP_INC, OP_DEC: begin
                res_o = as_sum;
                fout  = '{z: is_zero(as_sum), n: as_sub, h: as_h, c: fin.c};
                wr_o  = 1'b1;
            end
            OP_DADJ: begin
                res_o = da_res;
                fout  = '{z: is_zero(da_res), n: fin.n, h: 1'b0, c: da_c};
                wr_o  = 1'b1;
            end
            OP_CPL: begin
                res_o = ~acc_i;
                fout  = '{z: fin.z, n: 1'b1, h: 1'b1, c: fin.c};
                wr_o  = 1'b1;
            end
            OP_CCF: fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: ~fin.c};
            OP_SCF: fout = '{z: fin.z, n: 1'b0, h: 1'b0, c: 1'b1};
            default: ;
        endcase
    end

    assign flg_o = fout;

    always_ff @(posedge clk) begin
        if (rst)             flg_q <= '0;
        else if (op_valid_i) flg_q <= fout;
    end

    assign flg_q_o = flg_q;
endmodule

// File: rtl/alu_flag_chk.sv
module alu_flag_chk
    import alu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid_i,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] acc_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [FLAG_W-1:0] flg_i,
    input logic [DATA_W-1:0] res_o,
    input logic [FLAG_W-1:0] flg_o,
    input logic              wr_o,
    input logic [FLAG_W-1:0] flg_q_o
);
    assert_cmp_nowrite_R3: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd7) |-> (!wr_o && flg_o[2] && res_o == acc_i));

    assert_and_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd4) |-> (flg_o[2:0] == 3'b010 && flg_o[3] == (res_o == 8'h00)));

    assert_incdec_keepc_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd8 || op_i == 4'd9) |-> (flg_o[0] == flg_i[0] && flg_o[2] == op_i[0]));

    assert_cpl_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd11) |-> (res_o == ~acc_i && flg_o == {flg_i[3], 2'b11, flg_i[0]}));

    assert_carryops_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd12 || op_i == 4'd13) |-> (!wr_o && flg_o[3] == flg_i[3] && flg_o[2:1] == 2'b00));

    assert_dadj_h_R9: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd10) |-> (!flg_o[1] && flg_o[2] == flg_i[2] && wr_o));

    assert_nop_R11: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 4'd14) |-> (!wr_o && flg_o == flg_i && res_o == acc_i));

    assert_flag_load_R12: assert property (@(posedge clk) disable iff (rst)
        op_valid_i |=> (flg_q_o == $past(flg_o)));

    assert_flag_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !op_valid_i |=> $stable(flg_q_o));
endmodule

bind acc_alu alu_flag_chk u_flag_chk (.*);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid_i = 1'b0;
    logic [3:0] op_i = 4'd0;
    logic [7:0] acc_i = 8'd0;
    logic [7:0] opnd_i = 8'd0;
    logic [3:0] flg_i = 4'd0;
    logic [7:0] res_o;
    logic [3:0] flg_o;
    logic       wr_o;
    logic [3:0] flg_q_o;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    acc_alu dut (.*);

    always #10 clk = ~clk;

    // Reference: {wr, Z, N, H, C, result[7:0]}
    function automatic logic [12:0] ref_model(input int op, input int a, input int b, input logic [3:0] f);
        int s, lo, r, corr;
        logic z, n, h, c, wr;
        n = f[2]; h = f[1]; c = f[0]; z = f[3]; wr = 1'b0; r = a;
        case (op)
            0, 1: begin
                s  = a + b + ((op == 1) ? int'(f[0]) : 0);
                lo = (a % 16) + (b % 16) + ((op == 1) ? int'(f[0]) : 0);
                r = s % 256; n = 0; h = (lo > 15); c = (s > 255); wr = 1;
            end
            2, 3, 7: begin
                s  = a - b - ((op == 3) ? int'(f[0]) : 0);
                lo = (a % 16) - (b % 16) - ((op == 3) ? int'(f[0]) : 0);
                n = 1; h = (lo < 0); c = (s < 0);
                if (op != 7) begin r = (s + 256) % 256; wr = 1; end
                z = (((s + 256) % 256) == 0);
            end
            4: begin r = a & b; n = 0; h = 1; c = 0; wr = 1; end
            5: begin r = a | b; n = 0; h = 0; c = 0; wr = 1; end
            6: begin r = a ^ b; n = 0; h = 0; c = 0; wr = 1; end
            8: begin r = (b + 1) % 256; n = 0; h = ((b % 16) == 15); wr = 1; end
            9: begin r = (b + 255) % 256; n = 1; h = ((b % 16) == 0); wr = 1; end
            10: begin
                corr = 0;
                if (!f[2]) begin
                    if (f[1] || (a % 16) > 9) corr += 6;
                    if (f[0] || a > 153) begin corr += 96; c = 1; end
                    r = (a + corr) % 256;
                end else begin
                    if (f[1]) corr += 6;
                    if (f[0]) corr += 96;
                    r = (a - corr + 256) % 256;
                end
                h = 0; wr = 1;
            end
            11: begin r = 255 - a; n = 1; h = 1; wr = 1; end
            12: begin n = 0; h = 0; c = ~f[0]; end
            13: begin n = 0; h = 0; c = 1; end
            default: ;
        endcase
        if (op != 7 && op < 12 && op != 11) z = (r == 0);
        return {wr, z, n, h, c, 8'(r)};
    endfunction

    function automatic string tag_of(input int op, input logic [3:0] f);
        case (op)
            0, 1:   return "R1";
            2, 3:   return "R2";
            7:      return "R3";
            4:      return "R4";
            5, 6:   return "R5";
            8, 9:   return "R6";
            10:     return f[2] ? "R10" : "R9";
            11:     return "R7";
            12, 13: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(input int op, input int a, input int b, input logic [3:0] f);
        logic [12:0] exp_v, got_v;
        op_i = 4'(op); acc_i = 8'(a); opnd_i = 8'(b); flg_i = f;
        #1;
        exp_v = ref_model(op, a, b, f);
        got_v = {wr_o, flg_o, res_o};
        n_vec++;
        if (got_v !== exp_v) begin
            n_bad++;
            if (n_bad <= 30)
                $display("FAIL %s op=%0d a=%02h b=%02h f=%b actual={wr,f,res}=%b expected=%b",
                         tag_of(op, f), op, a, b, f, got_v, exp_v);
        end
    endtask

    task automatic check_q(input logic [3:0] exp_q, input string what);
        n_vec++;
        if (flg_q_o !== exp_q) begin
            n_bad++;
            $display("FAIL R12 %s actual=%b expected=%b", what, flg_q_o, exp_q);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d cycles expected=done", cycles);
            finish_run();
        end
    end

    initial begin
        logic [12:0] e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state of the flag register
        check_q(4'b0000, "after reset");
        // drive an op while reset is still high: register must stay clear
        op_i = 4'd13; flg_i = 4'b0000; op_valid_i = 1'b1;
        @(negedge clk);
        check_q(4'b0000, "reset dominates valid");
        op_valid_i = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R12: load on valid, hold when not valid
        for (int k = 0; k < 24; k++) begin
            op_i = 4'(k % 16); acc_i = 8'(k * 37); opnd_i = 8'(k * 91 + 5); flg_i = 4'(k * 7);
            op_valid_i = 1'b1;
            e = ref_model(k % 16, (k * 37) % 256, (k * 91 + 5) % 256, 4'(k * 7));
            @(negedge clk);
            check_q(e[11:8], "load on valid");
            op_valid_i = 1'b0;
            op_i = 4'd12; flg_i = ~flg_i;
            @(negedge clk);
            check_q(e[11:8], "hold without valid");
        end

        // R1-style sweep: two-operand ops, every operand pair, both carry-ins
        for (int op = 0; op < 8; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    for (int cb = 0; cb < 2; cb++)
                        apply(op, a, b, {a[7] ^ b[2], b[0], a[3] ^ b[3], cb[0]});

        // single-operand ops (R6, R7, R8, R9, R10, R11): every acc with every flag nibble
        for (int op = 8; op < 16; op++)
            for (int a = 0; a < 256; a++)
                for (int f = 0; f < 16; f++) begin
                    apply(op, a, a ^ (f * 17), 4'(f));
                    if (op == 8 || op == 9) apply(op, (a * 3) % 256, a, 4'(f));
                end

        // explicit corner cases
        apply(0, 8'h0F, 8'h01, 4'b0000);  // R1 half-carry only
        apply(0, 8'hFF, 8'h01, 4'b0000);  // R1 zero with carry
        apply(3, 8'h10, 8'h00, 4'b0001);  // R2 borrow into bit 4 from carry-in
        apply(7, 8'h42, 8'h42, 4'b0000);  // R3 equal compare
        apply(8, 8'h00, 8'hFF, 4'b0001);  // R6 wrap keeps C
        apply(9, 8'h00, 8'h00, 4'b0000);  // R6 borrow wrap keeps C clear
        apply(10, 8'h9A, 8'h00, 4'b0000); // R9 adjust past 0x99 to zero
        apply(10, 8'hFA, 8'h00, 4'b0111); // R10 adjust after subtraction

        finish_run();
    end
endmodule